// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers the interrupt sources that belong to a cluster of four cores and turns them into one IRQ line and one FIQ line per core. Each core contributes four level-sensitive timer lines and four mailbox-nonzero lines. A single GPU interrupt and a single PMU interrupt are shared by the whole cluster and are steered to cores by routing state.

Software programs the block through a 32-bit register port with a single-cycle write strobe and a combinational read path. Per-core enables are held in 8-bit control words. The low nibble of each word selects IRQ delivery and the high nibble selects FIQ delivery, and a FIQ enable always wins over the IRQ enable. The shared GPU source is routed by core-number fields. The PMU source has a per-core enable mask that is changed through set and clear aliases. For each core, two status words show which sources are pending as IRQ and which as FIQ. Each output line is the OR of its status word.

Top module: `core_irq_router`

## Requirements
- R1: After reset all control words, the GPU routing and the PMU mask are zero, every pending word reads zero and every output is low, even with all sources asserted.
- R2: Pending words use this layout: bits 3:0 are timers 0-3, bits 7:4 are mailboxes 0-3, bit 8 is the GPU source, bit 9 is the PMU source, and bits 31:10 are zero. The IRQ word of core c is read at 0x060+4c and the FIQ word at 0x070+4c.
- R3: The timer control word of core c is at 0x040+4c. Bit t (0-3) sends timer t as IRQ and bit 4+t sends it as FIQ. When both are set the source appears only as FIQ. Bits 7:0 read back and the upper bits read zero.
- R4: The mailbox control word of core c is at 0x050+4c, with the same bit meaning, the same FIQ precedence and the same readback as R3, applied to the mailbox lines.
- R5: The GPU routing word is at 0x00C. Bits 1:0 hold the IRQ target core, bits 3:2 the FIQ target core, bit 4 enables IRQ delivery and bit 5 enables FIQ delivery. With bit 5 set, the GPU source appears only at bit 8 of the FIQ word of the FIQ target core. Bits 5:0 read back.
- R6: Writing 1s to bits 3:0 at 0x010 sets those cores' PMU enables, and writing 1s at 0x014 clears them. Zero bits leave an enable unchanged. The mask reads back at 0x010 bits 3:0. An enabled core shows the PMU source at bit 9 of its IRQ word, and the PMU source never appears in a FIQ word.
- R7: No source is pending in both the IRQ word and the FIQ word of the same core.
- R8: irq_out[c] is high exactly when the IRQ word of core c is nonzero, and fiq_out[c] likewise for the FIQ word. Both follow the source inputs in the same cycle.
- R9: Writes to the pending words or to unmapped addresses change no state, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_in | input | 4*NCORE | Timer levels, core c at bits 4c+3:4c |
| mbox_in | input | 4*NCORE | Mailbox-nonzero levels, core c at bits 4c+3:4c |
| gpu_in | input | 1 | Shared GPU interrupt level |
| pmu_in | input | 1 | Shared PMU interrupt level |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_out | output | NCORE | Per-core IRQ request |
| fiq_out | output | NCORE | Per-core FIQ request |

## Verification
The sources are driven in several patterns: all asserted at once, one line walking across all cores, and random levels. The all-asserted pattern shows whether any unenabled path leaks through. The walking pattern shows whether a line lands on the right core and the right bit. The random levels, mixed with random register writes, expose mistakes in FIQ precedence and in the GPU and PMU routing, because a single write changes which word a source reaches. Writes that set and clear overlapping PMU bits, and writes to the read-only and unmapped addresses, check that a write changes only the state it names.

// File: rtl/core_irq_router.sv
module core_irq_router #(
  parameter int NCORE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4*NCORE-1:0] timer_in,
  input  logic [4*NCORE-1:0] mbox_in,
  input  logic               gpu_in,
  input  logic               pmu_in,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NCORE-1:0]   irq_out,
  output logic [NCORE-1:0]   fiq_out
);

  localparam logic [7:0] A_GPU  = 8'h0C;
  localparam logic [7:0] A_PSET = 8'h10;
  localparam logic [7:0] A_PCLR = 8'h14;
  localparam logic [7:0] A_TMR  = 8'h40;
  localparam logic [7:0] A_MBX  = 8'h50;
  localparam logic [7:0] A_IPND = 8'h60;
  localparam logic [7:0] A_FPND = 8'h70;

  logic [NCORE-1:0][7:0]  tmr_ctl, mbx_ctl;
  logic [5:0]             gpu_rt;
  logic [NCORE-1:0]       pmu_en;
  logic [NCORE-1:0][31:0] irq_w, fiq_w;
  logic [NCORE-1:0]       gpu_i, gpu_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_ctl <= '0;
      mbx_ctl <= '0;
      gpu_rt  <= '0;
      pmu_en  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_GPU)  gpu_rt <= reg_wdata[5:0];
      if (reg_addr == A_PSET) pmu_en <= pmu_en | reg_wdata[NCORE-1:0];
      if (reg_addr == A_PCLR) pmu_en <= pmu_en & ~reg_wdata[NCORE-1:0];
      for (int c = 0; c < NCORE; c++) begin
        if (reg_addr == A_TMR + 8'(4*c)) tmr_ctl[c] <= reg_wdata[7:0];
        if (reg_addr == A_MBX + 8'(4*c)) mbx_ctl[c] <= reg_wdata[7:0];
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    wire [3:0] tm = timer_in[4*c +: 4];
    wire [3:0] mb = mbox_in[4*c +: 4];

    assign gpu_f[c] = gpu_in & gpu_rt[5] & (gpu_rt[3:2] == 2'(c));
    assign gpu_i[c] = gpu_in & ~gpu_rt[5] & gpu_rt[4] & (gpu_rt[1:0] == 2'(c));

    assign fiq_w[c] = {22'b0, 1'b0, gpu_f[c],
                       mb & mbx_ctl[c][7:4], tm & tmr_ctl[c][7:4]};
    assign irq_w[c] = {22'b0, pmu_in & pmu_en[c], gpu_i[c],
                       mb & mbx_ctl[c][3:0] & ~mbx_ctl[c][7:4],
                       tm & tmr_ctl[c][3:0] & ~tmr_ctl[c][7:4]};

    assign irq_out[c] = |irq_w[c];
    assign fiq_out[c] = |fiq_w[c];

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_w[c] & fiq_w[c]) == 32'b0);
    assert_pmu_nofiq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fiq_w[c][9]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GPU)  reg_rdata[5:0] = gpu_rt;
    if (reg_addr == A_PSET) reg_rdata[NCORE-1:0] = pmu_en;
    for (int c = 0; c < NCORE; c++) begin
      if (reg_addr == A_TMR  + 8'(4*c)) reg_rdata[7:0] = tmr_ctl[c];
      if (reg_addr == A_MBX  + 8'(4*c)) reg_rdata[7:0] = mbx_ctl[c];
      if (reg_addr == A_IPND + 8'(4*c)) reg_rdata = irq_w[c];
      if (reg_addr == A_FPND + 8'(4*c)) reg_rdata = fiq_w[c];
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (tmr_ctl == '0 && mbx_ctl == '0 && gpu_rt == '0 && pmu_en == '0));

  assert_gpu_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpu_i, gpu_f}));

  assert_pmu_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_PSET |=>
      (pmu_en & $past(reg_wdata[NCORE-1:0])) == $past(reg_wdata[NCORE-1:0]));

  assert_pmu_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_PCLR |=>
      (pmu_en & $past(reg_wdata[NCORE-1:0])) == '0);

  assert_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr[7:5] == 3'b011 || reg_addr >= 8'h80) |=>
      $stable({tmr_ctl, mbx_ctl, gpu_rt, pmu_en}));

endmodule

// File: tb/core_irq_router_tb.sv
module core_irq_router_tb;
  localparam int NC = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] timer_in = '0, mbox_in = '0;
  logic        gpu_in = 0, pmu_in = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] irq_out, fiq_out;

  int vectors = 0, misses = 0;

  logic [7:0] m_tc [NC];
  logic [7:0] m_mc [NC];
  logic [5:0] m_gr;
  logic [3:0] m_pe;

  always #10 clk = ~clk;

  core_irq_router #(.NCORE(NC)) u_dut (.*);

  function automatic logic [31:0] exp_irq(int c);
    logic [31:0] w = '0;
    for (int t = 0; t < 4; t++) begin
      if (timer_in[4*c+t] && m_tc[c][t] && !m_tc[c][4+t]) w[t] = 1;
      if (mbox_in[4*c+t] && m_mc[c][t] && !m_mc[c][4+t]) w[4+t] = 1;
    end
    if (gpu_in && !m_gr[5] && m_gr[4] && m_gr[1:0] == 2'(c)) w[8] = 1;
    if (pmu_in && m_pe[c]) w[9] = 1;
    return w;
  endfunction

  function automatic logic [31:0] exp_fiq(int c);
    logic [31:0] w = '0;
    for (int t = 0; t < 4; t++) begin
      if (timer_in[4*c+t] && m_tc[c][4+t]) w[t] = 1;
      if (mbox_in[4*c+t] && m_mc[c][4+t]) w[4+t] = 1;
    end
    if (gpu_in && m_gr[5] && m_gr[3:2] == 2'(c)) w[8] = 1;
    return w;
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    cmp(reg_rdata, exp, req, $sformatf("read %h", a));
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      rd(8'h60 + 8'(4*c), exp_irq(c), {req, "/R2"});
      rd(8'h70 + 8'(4*c), exp_fiq(c), {req, "/R2"});
      cmp(32'(irq_out[c]), 32'(exp_irq(c) != 0), {req, "/R8"}, $sformatf("irq_out[%0d]", c));
      cmp(32'(fiq_out[c]), 32'(exp_fiq(c) != 0), {req, "/R8"}, $sformatf("fiq_out[%0d]", c));
      rd(8'h40 + 8'(4*c), 32'(m_tc[c]), {req, "/R3"});
      rd(8'h50 + 8'(4*c), 32'(m_mc[c]), {req, "/R4"});
    end
    rd(8'h0C, 32'(m_gr), {req, "/R5"});
    rd(8'h10, 32'(m_pe), {req, "/R6"});
    rd(8'hA8, 32'h0, {req, "/R9"});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 0;
    if (a == 8'h0C) m_gr = d[5:0];
    if (a == 8'h10) m_pe = m_pe | d[3:0];
    if (a == 8'h14) m_pe = m_pe & ~d[3:0];
    for (int c = 0; c < NC; c++) begin
      if (a == 8'h40 + 8'(4*c)) m_tc[c] = d[7:0];
      if (a == 8'h50 + 8'(4*c)) m_mc[c] = d[7:0];
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [14];
    for (int c = 0; c < NC; c++) begin m_tc[c] = '0; m_mc[c] = '0; end
    m_gr = '0; m_pe = '0;
    addrs = '{8'h0C, 8'h10, 8'h14, 8'h40, 8'h44, 8'h48, 8'h4C,
              8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h74, 8'hA8};

    timer_in = '1; mbox_in = '1; gpu_in = 1; pmu_in = 1;
    repeat (3) @(posedge clk);
    rst_n = 1;
    check_all("R1");

    wr(8'h40, 32'h0F); wr(8'h44, 32'hF0); wr(8'h48, 32'h35); wr(8'h4C, 32'hFFFF_FF81);
    check_all("R3");
    wr(8'h50, 32'hA5); wr(8'h54, 32'h0F); wr(8'h5C, 32'hCC);
    check_all("R4");

    timer_in = '0; mbox_in = '0;
    for (int i = 0; i < 16; i++) begin
      timer_in = 16'(1) << i;
      mbox_in  = 16'(1) << (15 - i);
      check_all("R7");
    end

    wr(8'h0C, 32'h12); check_all("R5");
    wr(8'h0C, 32'h3E); check_all("R5");
    wr(8'h0C, 32'h0D); check_all("R5");

    wr(8'h10, 32'h5); check_all("R6");
    wr(8'h10, 32'hA); check_all("R6");
    wr(8'h14, 32'h3); check_all("R6");
    wr(8'h14, 32'h0); check_all("R6");

    wr(8'h60, 32'hFFFF_FFFF); wr(8'h74, 32'hFFFF_FFFF);
    wr(8'hA8, 32'hFFFF_FFFF); wr(8'h42, 32'hFFFF_FFFF);
    check_all("R9");

    for (int n = 0; n < 300; n++) begin
      timer_in = 16'($urandom); mbox_in = 16'($urandom);
      gpu_in = 1'($urandom); pmu_in = 1'($urandom);
      if ($urandom_range(0, 1) == 1) wr(addrs[$urandom_range(0, 13)], $urandom);
      check_all("R8");
    end

    rst_n = 0;
    for (int c = 0; c < NC; c++) begin m_tc[c] = '0; m_mc[c] = '0; end
    m_gr = '0; m_pe = '0;
    timer_in = '1; mbox_in = '1; gpu_in = 1; pmu_in = 1;
    repeat (2) @(posedge clk);
    rst_n = 1;
    check_all("R1");

    finish_run();
  end
endmodule